// File: doc/BRIEF.md
# Descriptor register store unit

This unit carries out the store of a descriptor-table register (a 16-bit limit plus a base address) to memory. A one-cycle `start` pulse hands it the current execution mode, the operand size, the privilege level and a set of control bits, together with the outcome of checks made elsewhere on the destination address: segment limit, writability, null selector and canonical form. From these it first decides whether the store must fault. A fault is reported as a one-cycle strobe carrying a 3-bit code in the cycle after `start`. In that case no memory traffic takes place.

When no fault applies, the unit captures the register image and emits it as byte beats, lowest address first, on a valid/ready stream. A beat is transferred on a cycle where both `beat_valid` and `beat_ready` are high. While `beat_ready` is low, the unit holds the same beat with its data and index unchanged, and it never withdraws a beat it has offered. Memory reports a page fault through `beat_pf` alongside `beat_ready`. That beat counts as transferred, no further beats follow, and a page-fault code is reported. A clean end of the stream is marked by a one-cycle `done` pulse. Address generation, segmentation and paging themselves are done outside the unit, and the store changes no status flags.

Top module: `dtstore_unit`

## Requirements
- R1: Outside 64-bit mode the image is 6 bytes. Beat 0 is limit[7:0], beat 1 is limit[15:8], and beats 2 to 5 are base[7:0] up to base[31:0] in ascending order.
- R2: In 64-bit mode (`mode`=3) the image is 10 bytes. Beats 0 and 1 carry the limit, and beats 2 to 9 carry base[63:0], low byte first.
- R3: With parameter `LEGACY_FILL`=1, `op16`=1 and a mode other than 64-bit, beat 5 is 8'hFF. In every other case beat 5 carries base[31:24].
- R4: `lock_pfx`=1 gives fault code 1 (invalid opcode) in every mode, ahead of all other faults. Mode encoding: 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit.
- R5: `prevent`=1 gives code 2 (general protection) in modes 2 and 3 when `cpl` is not 0, and in mode 1 at any `cpl`. Mode 0 ignores it. This check ranks below R4.
- R6: In mode 3, `noncanon` gives code 3 (stack) if `canon_stack` is set and code 2 otherwise, and `lim_viol` is ignored. In modes 0 to 2, `lim_viol` gives code 3 if `lim_stack` is set and code 2 otherwise. In mode 2 only, `not_writable` or `null_sel` gives code 2. This check ranks below R5.
- R7: `align_en` and `unaligned` together give code 4 (alignment) in modes 2 and 3 only at `cpl`=3, and in mode 1 at any `cpl`. Mode 0 never raises it. This check ranks below R6.
- R8: A fault found at start is reported by `fault_valid` high for exactly the one cycle after `start`. No beat is offered for that store.
- R9: Beats go out one per cycle at most, with `beat_idx` counting 0, 1, 2 and so on. While `beat_ready` is low, `beat_valid`, `beat_data` and `beat_idx` hold steady.
- R10: `done` is high for exactly one cycle, in the cycle after the last beat is transferred. `done` and `fault_valid` are never high together.
- R11: A transferred beat with `beat_pf`=1 ends the stream. In the next cycle `fault_valid`=1 with code 5 and `beat_valid`=0, and no `done` follows.
- R12: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one store (taken only while idle) |
| mode | input | 2 | Execution mode: 0 real, 1 virtual-8086, 2 protected/compat, 3 64-bit |
| op16 | input | 1 | Operand size is 16 bits |
| lock_pfx | input | 1 | LOCK prefix present |
| prevent | input | 1 | User-mode instruction prevention control bit |
| cpl | input | 2 | Current privilege level |
| align_en | input | 1 | Alignment checking enabled |
| unaligned | input | 1 | Destination address is unaligned |
| lim_viol | input | 1 | Destination exceeds its segment limit |
| lim_stack | input | 1 | Access references the stack segment (limit case) |
| not_writable | input | 1 | Destination segment not writable |
| null_sel | input | 1 | Data segment register holds a null selector |
| noncanon | input | 1 | Address not canonical (64-bit mode) |
| canon_stack | input | 1 | Access references the stack segment (canonical case) |
| reg_limit | input | LIM_W | Register limit field |
| reg_base | input | BASE_W | Register base field |
| beat_valid | output | 1 | Byte beat offered |
| beat_ready | input | 1 | Memory accepts the beat |
| beat_pf | input | 1 | Page fault on the beat being accepted |
| beat_data | output | 8 | Beat byte |
| beat_idx | output | IDX_W | Byte offset of the beat |
| busy | output | 1 | Store in progress |
| done | output | 1 | Store completed |
| fault_valid | output | 1 | Fault strobe |
| fault_code | output | 3 | 1 opcode, 2 protection, 3 stack, 4 alignment, 5 page |

## Verification
A page-fault response and the end of the stream can fall on the same beat. A page fault raised on the final beat of the image must turn the `done` pulse that would otherwise follow into a code-5 fault. The bench provokes this by arming `beat_pf` at the last index, and also at a middle index under back-pressure. Its scoreboard expects exactly the beats up to and including the faulting one, followed by a single fault event with no `done`. A stray `start` pulse issued while beats are still pending is a second such overlap. It must produce no extra event, and the scoreboard flags any unexpected strobe.

// File: rtl/dtstore_pkg.sv
package dtstore_pkg;

  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_V86  = 2'd1,
    MD_PROT = 2'd2,
    MD_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_BADOP = 3'd1,
    FC_PROT  = 3'd2,
    FC_STACK = 3'd3,
    FC_ALIGN = 3'd4,
    FC_PAGE  = 3'd5
  } fault_e;

  typedef struct packed {
    logic       lock_pfx;
    logic       prevent;
    logic [1:0] cpl;
    logic       align_en;
    logic       unaligned;
    logic       lim_viol;
    logic       lim_stack;
    logic       not_writable;
    logic       null_sel;
    logic       noncanon;
    logic       canon_stack;
  } chk_in_t;

endpackage

// File: rtl/dtstore_fault_eval.sv
module dtstore_fault_eval
  import dtstore_pkg::*;
(
  input  cpu_mode_e mode,
  input  chk_in_t   ck,
  output fault_e    code
);

  logic paged_mode;
  logic priv_f;
  logic addr_f;
  logic addr_stk;
  logic align_f;

  assign paged_mode = (mode == MD_PROT) || (mode == MD_LONG);

  // privilege / prevention rule
  assign priv_f = ck.prevent &&
                  ((paged_mode && (ck.cpl != 2'd0)) || (mode == MD_V86));

  // addressing rule: canonical form in 64-bit, limits and attributes elsewhere
  always_comb begin
    addr_f   = 1'b0;
    addr_stk = 1'b0;
    if (mode == MD_LONG) begin
      addr_f   = ck.noncanon;
      addr_stk = ck.canon_stack;
    end else if (ck.lim_viol) begin
      addr_f   = 1'b1;
      addr_stk = ck.lim_stack;
    end else if (mode == MD_PROT) begin
      addr_f   = ck.not_writable || ck.null_sel;
      addr_stk = 1'b0;
    end
  end

  assign align_f = ck.align_en && ck.unaligned &&
                   ((paged_mode && (ck.cpl == 2'd3)) || (mode == MD_V86));

  always_comb begin
    if (ck.lock_pfx)  code = FC_BADOP;
    else if (priv_f)  code = FC_PROT;
    else if (addr_f)  code = addr_stk ? FC_STACK : FC_PROT;
    else if (align_f) code = FC_ALIGN;
    else              code = FC_NONE;
  end

endmodule

// File: rtl/dtstore_image.sv
module dtstore_image
  import dtstore_pkg::*;
#(
  parameter int LIM_W       = 16,
  parameter int BASE_W      = 64,
  parameter bit LEGACY_FILL = 1'b1,
  parameter int IMG_BYTES   = (LIM_W + BASE_W) / 8,
  parameter int CNT_W       = $clog2(IMG_BYTES + 1)
)(
  input  cpu_mode_e              mode,
  input  logic                   op16,
  input  logic [LIM_W-1:0]       limit,
  input  logic [BASE_W-1:0]      base,
  output logic [IMG_BYTES*8-1:0] img,
  output logic [CNT_W-1:0]       len
);

  localparam int LIM_BYTES   = LIM_W / 8;
  localparam int SHORT_BYTES = LIM_BYTES + 4;

  logic long_m;
  logic fill_top;

  assign long_m   = (mode == MD_LONG);
  assign fill_top = LEGACY_FILL && op16 && !long_m;

  for (genvar i = 0; i < IMG_BYTES; i++) begin : g_byte
    if (i < LIM_BYTES) begin : g_lim
      assign img[i*8 +: 8] = limit[i*8 +: 8];
    end else if (i == SHORT_BYTES - 1) begin : g_top
      assign img[i*8 +: 8] = fill_top ? 8'hFF : base[(i-LIM_BYTES)*8 +: 8];
    end else begin : g_base
      assign img[i*8 +: 8] = base[(i-LIM_BYTES)*8 +: 8];
    end
  end

  assign len = long_m ? CNT_W'(IMG_BYTES) : CNT_W'(SHORT_BYTES);

endmodule

// File: rtl/dtstore_beat_seq.sv
module dtstore_beat_seq
  import dtstore_pkg::*;
#(
  parameter int IMG_BYTES = 10,
  parameter int CNT_W     = $clog2(IMG_BYTES + 1)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  fault_e                 pre_code,
  input  logic [IMG_BYTES*8-1:0] img,
  input  logic [CNT_W-1:0]       len,
  output logic                   beat_valid,
  input  logic                   beat_ready,
  input  logic                   beat_pf,
  output logic [7:0]             beat_data,
  output logic [CNT_W-1:0]       beat_idx,
  output logic                   busy,
  output logic                   done,
  output logic                   fault_valid,
  output fault_e                 fault_code
);

  typedef enum logic {ST_IDLE, ST_SEND} st_e;

  st_e                    st;
  logic [IMG_BYTES*8-1:0] img_q;
  logic [CNT_W-1:0]       len_q;
  logic [CNT_W-1:0]       idx_q;
  logic                   last_beat;
  logic                   xfer;

  assign last_beat  = (idx_q == len_q - CNT_W'(1));
  assign beat_valid = (st == ST_SEND);
  assign xfer       = beat_valid && beat_ready;
  assign beat_idx   = idx_q;
  assign beat_data  = img_q[{idx_q, 3'b000} +: 8];
  assign busy       = (st == ST_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      img_q       <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      done        <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FC_NONE;
    end else begin
      done        <= 1'b0;
      fault_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (pre_code != FC_NONE) begin
              fault_valid <= 1'b1;
              fault_code  <= pre_code;
            end else begin
              st    <= ST_SEND;
              img_q <= img;
              len_q <= len;
              idx_q <= '0;
            end
          end
        end
        ST_SEND: begin
          if (xfer) begin
            if (beat_pf) begin
              fault_valid <= 1'b1;
              fault_code  <= FC_PAGE;
              st          <= ST_IDLE;
            end else if (last_beat) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dtstore_unit.sv
module dtstore_unit
  import dtstore_pkg::*;
#(
  parameter int LIM_W       = 16,
  parameter int BASE_W      = 64,
  parameter bit LEGACY_FILL = 1'b1
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mode,
  input  logic                   op16,
  input  logic                   lock_pfx,
  input  logic                   prevent,
  input  logic [1:0]             cpl,
  input  logic                   align_en,
  input  logic                   unaligned,
  input  logic                   lim_viol,
  input  logic                   lim_stack,
  input  logic                   not_writable,
  input  logic                   null_sel,
  input  logic                   noncanon,
  input  logic                   canon_stack,
  input  logic [LIM_W-1:0]       reg_limit,
  input  logic [BASE_W-1:0]      reg_base,
  output logic                   beat_valid,
  input  logic                   beat_ready,
  input  logic                   beat_pf,
  output logic [7:0]             beat_data,
  output logic [$clog2((LIM_W+BASE_W)/8+1)-1:0] beat_idx,
  output logic                   busy,
  output logic                   done,
  output logic                   fault_valid,
  output logic [2:0]             fault_code
);

  localparam int IMG_BYTES = (LIM_W + BASE_W) / 8;
  localparam int IDX_W     = $clog2(IMG_BYTES + 1);

  cpu_mode_e              mode_e;
  chk_in_t                ck;
  fault_e                 pre_code;
  fault_e                 seq_code;
  logic [IMG_BYTES*8-1:0] img;
  logic [IDX_W-1:0]       len;

  assign mode_e = cpu_mode_e'(mode);

  assign ck = '{lock_pfx:     lock_pfx,
                prevent:      prevent,
                cpl:          cpl,
                align_en:     align_en,
                unaligned:    unaligned,
                lim_viol:     lim_viol,
                lim_stack:    lim_stack,
                not_writable: not_writable,
                null_sel:     null_sel,
                noncanon:     noncanon,
                canon_stack:  canon_stack};

  dtstore_fault_eval u_fault (
    .mode (mode_e),
    .ck   (ck),
    .code (pre_code)
  );

  dtstore_image #(
    .LIM_W       (LIM_W),
    .BASE_W      (BASE_W),
    .LEGACY_FILL (LEGACY_FILL),
    .IMG_BYTES   (IMG_BYTES),
    .CNT_W       (IDX_W)
  ) u_image (
    .mode  (mode_e),
    .op16  (op16),
    .limit (reg_limit),
    .base  (reg_base),
    .img   (img),
    .len   (len)
  );

  dtstore_beat_seq #(
    .IMG_BYTES (IMG_BYTES),
    .CNT_W     (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pre_code    (pre_code),
    .img         (img),
    .len         (len),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_pf     (beat_pf),
    .beat_data   (beat_data),
    .beat_idx    (beat_idx),
    .busy        (busy),
    .done        (done),
    .fault_valid (fault_valid),
    .fault_code  (seq_code)
  );

  assign fault_code = seq_code;

endmodule

// File: rtl/dtstore_chk.sv
module dtstore_chk #(
  parameter int IDX_W = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             lock_pfx,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic             beat_pf,
  input logic [7:0]       beat_data,
  input logic [IDX_W-1:0] beat_idx,
  input logic             done,
  input logic             fault_valid,
  input logic [2:0]       fault_code
);

  assert_lock_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && lock_pfx) |=> (fault_valid && fault_code == 3'd1 && !beat_valid));

  assert_fault_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_code != 3'd5) |-> !beat_valid);

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data) && $stable(beat_idx)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault_valid));

  assert_page_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_pf) |=> (fault_valid && fault_code == 3'd5 && !beat_valid && !done));

  assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !(beat_valid && beat_ready && beat_pf)) |=> !fault_valid);

endmodule

bind dtstore_unit dtstore_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_dtstore_unit.sv
module test_dtstore_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        op16 = 1'b0;
  logic        lock_pfx = 1'b0, prevent = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        align_en = 1'b0, unaligned = 1'b0;
  logic        lim_viol = 1'b0, lim_stack = 1'b0;
  logic        not_writable = 1'b0, null_sel = 1'b0;
  logic        noncanon = 1'b0, canon_stack = 1'b0;
  logic [15:0] reg_limit = 16'h0;
  logic [63:0] reg_base = 64'h0;
  logic        beat_valid, beat_ready, beat_pf;
  logic [7:0]  beat_data;
  logic [3:0]  beat_idx;
  logic        busy, done, fault_valid;
  logic [2:0]  fault_code;

  bit          stall_on = 1'b0;
  bit          pf_arm = 1'b0;
  int          pf_at = 0;
  int unsigned rcnt = 0;
  int          checks = 0;
  int          errors = 0;
  string       cur_req = "R0";

  typedef struct { bit is_fault; bit [2:0] code; } ev_t;
  ev_t          evq[$];
  bit [7:0]     bq[$];
  int           iq[$];

  always #2.5 clk = ~clk;

  assign beat_pf = pf_arm && (int'(beat_idx) == pf_at);

  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    #1 beat_ready = stall_on ? ((rcnt % 3) != 1) : 1'b1;
  end

  dtstore_unit #(.LIM_W(16), .BASE_W(64), .LEGACY_FILL(1'b1)) i_dtstore_unit (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  bit       hold_pend = 1'b0;
  bit [7:0] hold_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check(beat_valid && beat_data == hold_data, "R9", "held beat", beat_data, hold_data);
        hold_pend = 1'b0;
      end
      if (beat_valid && !beat_ready) begin
        hold_pend = 1'b1;
        hold_data = beat_data;
      end
      if (beat_valid && beat_ready) begin
        if (bq.size() == 0) check(1'b0, cur_req, "unexpected beat", beat_idx, 0);
        else begin
          bit [7:0] eb;
          int ei;
          eb = bq.pop_front();
          ei = iq.pop_front();
          check(beat_data == eb, cur_req, "beat data", beat_data, eb);
          check(int'(beat_idx) == ei, "R9", "beat index", beat_idx, ei);
        end
      end
      if (done || fault_valid) begin
        if (evq.size() == 0) check(1'b0, cur_req, "unexpected event", {done, fault_code}, 0);
        else begin
          ev_t e;
          e = evq.pop_front();
          check(fault_valid == e.is_fault && done == !e.is_fault, cur_req, "event kind",
                fault_valid, e.is_fault);
          if (e.is_fault) check(fault_code == e.code, cur_req, "fault code", fault_code, e.code);
        end
      end
    end
  end

  function automatic bit [2:0] model_code();
    bit paged;
    paged = (mode == 2'd2) || (mode == 2'd3);
    if (lock_pfx) return 3'd1;
    if (prevent && ((paged && cpl != 0) || mode == 2'd1)) return 3'd2;
    if (mode == 2'd3) begin
      if (noncanon) return canon_stack ? 3'd3 : 3'd2;
    end else if (lim_viol) return lim_stack ? 3'd3 : 3'd2;
    else if (mode == 2'd2 && (not_writable || null_sel)) return 3'd2;
    if (align_en && unaligned && ((paged && cpl == 3) || mode == 2'd1)) return 3'd4;
    return 3'd0;
  endfunction

  task automatic clear_ins();
    mode = 2'd2; op16 = 0; lock_pfx = 0; prevent = 0; cpl = 0;
    align_en = 0; unaligned = 0; lim_viol = 0; lim_stack = 0;
    not_writable = 0; null_sel = 0; noncanon = 0; canon_stack = 0;
    pf_arm = 0; stall_on = 0;
  endtask

  task automatic go(input string req, input bit poke);
    bit [2:0] c;
    int       len;
    bit       pf_hit;
    ev_t      e;
    cur_req = req;
    c = model_code();
    if (c != 0) begin
      e.is_fault = 1; e.code = c; evq.push_back(e);
    end else begin
      len = (mode == 2'd3) ? 10 : 6;
      pf_hit = 0;
      for (int i = 0; i < len; i++) begin
        bit [7:0] b;
        if (i < 2) b = reg_limit[i*8 +: 8];
        else b = reg_base[(i-2)*8 +: 8];
        if (i == 5 && mode != 2'd3 && op16) b = 8'hFF;
        bq.push_back(b); iq.push_back(i);
        if (pf_arm && i == pf_at) begin pf_hit = 1; break; end
      end
      e.is_fault = pf_hit; e.code = pf_hit ? 3'd5 : 3'd0; evq.push_back(e);
    end
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (poke) begin
      @(posedge clk); #1 lock_pfx = 1'b1; start = 1'b1;
      @(posedge clk); #1 lock_pfx = 1'b0; start = 1'b0;
    end
    while (evq.size() != 0 || bq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !beat_valid, req, "idle after store", busy, 0);
    clear_ins();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R0 actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    beat_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(!busy && !beat_valid && !done && !fault_valid, "R8", "reset state",
          {busy, beat_valid, done, fault_valid}, 0);

    reg_limit = 16'hA51C; reg_base = 64'hF1E2_D3C4_B5A6_9788;
    go("R1", 0);                                   // protected, 32-bit
    op16 = 1; go("R3", 0);                         // legacy top byte fill
    mode = 0; op16 = 1; go("R3", 0);               // real, 16-bit
    mode = 0; go("R1", 0);                         // real, 32-bit
    mode = 3; stall_on = 1; go("R2", 0);           // 64-bit with back-pressure
    mode = 3; op16 = 1; go("R2", 0);               // no fill in 64-bit
    reg_limit = 16'h0003; reg_base = 64'h0123_4567_89AB_CDEF;

    mode = 0; lock_pfx = 1; go("R4", 0);
    mode = 3; lock_pfx = 1; go("R4", 0);
    mode = 2; lock_pfx = 1; prevent = 1; cpl = 3; lim_viol = 1; go("R4", 0);

    mode = 2; prevent = 1; cpl = 0; go("R5", 0);   // runs
    mode = 2; prevent = 1; cpl = 1; go("R5", 0);   // code 2
    mode = 3; prevent = 1; cpl = 3; lim_viol = 1; lim_stack = 1; go("R5", 0);
    mode = 1; prevent = 1; cpl = 0; go("R5", 0);   // code 2
    mode = 0; prevent = 1; cpl = 3; go("R5", 0);   // ignored

    mode = 3; noncanon = 1; canon_stack = 1; go("R6", 0);
    mode = 3; noncanon = 1; go("R6", 0);
    mode = 3; lim_viol = 1; lim_stack = 1; go("R6", 0);   // ignored
    mode = 2; lim_viol = 1; lim_stack = 1; align_en = 1; unaligned = 1; cpl = 3; go("R6", 0);
    mode = 0; lim_viol = 1; go("R6", 0);
    mode = 2; not_writable = 1; go("R6", 0);
    mode = 2; null_sel = 1; go("R6", 0);
    mode = 1; null_sel = 1; not_writable = 1; go("R6", 0); // ignored

    mode = 2; align_en = 1; unaligned = 1; cpl = 3; go("R7", 0);
    mode = 2; align_en = 1; unaligned = 1; cpl = 2; go("R7", 0);
    mode = 1; align_en = 1; unaligned = 1; cpl = 0; go("R7", 0);
    mode = 0; align_en = 1; unaligned = 1; cpl = 3; go("R7", 0);
    mode = 3; align_en = 1; unaligned = 1; cpl = 3; go("R7", 0);
    mode = 3; align_en = 0; unaligned = 1; cpl = 3; go("R7", 0);

    mode = 2; stall_on = 1; pf_arm = 1; pf_at = 3; go("R11", 0);
    mode = 2; pf_arm = 1; pf_at = 5; go("R11", 0);         // last beat
    mode = 3; pf_arm = 1; pf_at = 0; go("R11", 0);
    mode = 3; stall_on = 1; go("R10", 0);

    mode = 3; stall_on = 1; go("R12", 1);                  // start while busy
    mode = 2; go("R12", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule